// File: doc/BRIEF.md
# Receive Character Queue with Error Summary

This block is the receive-side character queue of a serial port channel. The deserializer pushes each character together with three error bits: parity, framing and break. The queue keeps those bits alongside the character. The oldest stored character and its own error bits appear on the head outputs. Software consumes the head by reading the data register, which is modelled as a one-cycle pop strobe.

The block also drives a summary error output. It stays high as long as at least one character still inside the queue carries an error bit. It drops only after the last such character has been popped. A separate status-read strobe models a read of the line status register. It never removes a character. Its only effect is to clear the sticky overrun indication.

A write into a full queue is discarded and raises overrun. A synchronous clear input empties the queue in one cycle.

Top module: `rxq_err_fifo`

## Requirements
- R1: Characters leave in the order they were accepted. The queue holds up to DEPTH (default 64) entries. `level` gives the entry count, `empty` is high when the count is 0, and `full` is high when the count is DEPTH.
- R2: While the queue is not empty, `head_data` and `head_flags` show the oldest entry, with `head_flags` encoded as bit0 = parity, bit1 = framing, bit2 = break. While the queue is empty, both outputs read zero.
- R3: `err_any` is high whenever at least one held entry has a nonzero flag field. It is low when the queue is empty.
- R4: Popping entries that have no error leaves `err_any` high while an erroneous entry remains. `err_any` falls in the cycle after the last erroneous entry is popped.
- R5: `rd_stat_stb` never removes an entry. `level`, `head_data` and `err_any` are unchanged by it.
- R6: A push and a pop in the same cycle leave `level` unchanged. The error summary follows the net change: an erroneous entry pushed while another erroneous entry is popped keeps `err_any` high.
- R7: A write while `full` is high is dropped. `level` and the stored entries are unchanged, and `overrun` goes high one cycle later. `overrun` stays high until a `rd_stat_stb` cycle that has no new overrun.
- R8: A pop strobe while the queue is empty is ignored.
- R9: When `clr` is high at a clock edge, `level` becomes 0, `empty` becomes 1, and `err_any` and `overrun` become 0. Any push or pop in the same cycle is ignored.
- R10: After the asynchronous active-low reset, the queue is empty, `full` is 0, `err_any` is 0 and `overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous queue clear |
| wr_en | input | 1 | Push strobe from the deserializer |
| wr_data | input | DATA_W | Received character |
| wr_flags | input | 3 | Error bits of the character (bit0 parity, bit1 framing, bit2 break) |
| rd_data_stb | input | 1 | Data-register read: pops the head entry |
| rd_stat_stb | input | 1 | Status-register read: clears overrun, never pops |
| head_data | output | DATA_W | Oldest character, zero when empty |
| head_flags | output | 3 | Error bits of the oldest character, zero when empty |
| err_any | output | 1 | An entry with an error is held |
| level | output | $clog2(DEPTH+1) | Number of held entries |
| empty | output | 1 | Queue holds no entry |
| full | output | 1 | Queue holds DEPTH entries |
| overrun | output | 1 | Sticky: a write was dropped because the queue was full |

## Verification
The queue is driven through a mix of sequences:
- Clean and erroneous characters are interleaved, so a summary tied to the head entry can be told apart from one that covers the whole queue.
- Push and pop are driven in the same cycle, once with both entries erroneous and once with only the outgoing entry erroneous. This separates a net update of the error count from one that drops one of its two changes.
- Status reads are mixed into the traffic to show that they leave the head in place.

A full fill is run with one error placed at slot 10, followed by a full drain with wrapped pointers. This shows that the summary falls exactly after the eleventh pop, that the order is kept across the wrap, and that a write while full alters nothing.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int FLAG_W = 3;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxq_flags_t;

endpackage

// File: rtl/rxq_mem.sv
module rxq_mem
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  rxq_flags_t        wflags,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output rxq_flags_t        rflags
);

    typedef struct packed {
        rxq_flags_t        flags;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slots_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slots_q[waddr] <= '{flags: wflags, data: wdata};
        end
    end

    always_comb begin
        rdata  = slots_q[raddr].data;
        rflags = slots_q[raddr].flags;
    end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          stat_rd,
    output logic          push,
    output logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          full,
    output logic          overrun
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] lvl;
        logic          ovr;
    } ctrl_t;

    ctrl_t st_q, st_d;

    always_comb begin
        empty = (st_q.lvl == '0);
        full  = (st_q.lvl == CAP);
        push  = wr_en && !full && !clr;
        pop   = rd_en && !empty && !clr;

        st_d = st_q;
        if (push) begin
            st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.lvl = st_q.lvl + 1'b1;
            2'b01:   st_d.lvl = st_q.lvl - 1'b1;
            default: st_d.lvl = st_q.lvl;
        endcase
        if (wr_en && full) begin
            st_d.ovr = 1'b1;
        end else if (stat_rd) begin
            st_d.ovr = 1'b0;
        end
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr  = st_q.wr;
    assign rd_ptr  = st_q.rd;
    assign level   = st_q.lvl;
    assign overrun = st_q.ovr;

endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic err_any
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ecnt_t;

    ecnt_t ec_q, ec_d;

    always_comb begin
        ec_d = ec_q;
        case ({inc, dec})
            2'b10:   ec_d.cnt = ec_q.cnt + 1'b1;
            2'b01:   ec_d.cnt = ec_q.cnt - 1'b1;
            default: ec_d.cnt = ec_q.cnt;
        endcase
        if (clr) begin
            ec_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ec_q <= '0;
        end else begin
            ec_q <= ec_d;
        end
    end

    assign err_any = (ec_q.cnt != '0);

endmodule

// File: rtl/rxq_err_fifo.sv
module rxq_err_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic              rd_data_stb,
    input  logic              rd_stat_stb,
    output logic [DATA_W-1:0] head_data,
    output logic [FLAG_W-1:0] head_flags,
    output logic              err_any,
    output logic [CW-1:0]     level,
    output logic              empty,
    output logic              full,
    output logic              overrun
);

    logic              push, pop;
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [DATA_W-1:0] mem_data;
    rxq_flags_t        mem_flags;
    rxq_flags_t        in_flags;

    assign in_flags = rxq_flags_t'(wr_flags);

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (wr_en),
        .rd_en   (rd_data_stb),
        .stat_rd (rd_stat_stb),
        .push    (push),
        .pop     (pop),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .level   (level),
        .empty   (empty),
        .full    (full),
        .overrun (overrun)
    );

    rxq_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk    (clk),
        .we     (push),
        .waddr  (wr_ptr),
        .wdata  (wr_data),
        .wflags (in_flags),
        .raddr  (rd_ptr),
        .rdata  (mem_data),
        .rflags (mem_flags)
    );

    rxq_errcnt #(.DEPTH(DEPTH)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .inc     (push && (in_flags != '0)),
        .dec     (pop && (mem_flags != '0)),
        .err_any (err_any)
    );

    always_comb begin
        head_data  = empty ? '0 : mem_data;
        head_flags = empty ? '0 : FLAG_W'(mem_flags);
    end

endmodule

// File: rtl/rxq_err_fifo_chk.sv
module rxq_err_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              wr_en,
    input logic              rd_data_stb,
    input logic              rd_stat_stb,
    input logic [DATA_W-1:0] head_data,
    input logic              err_any,
    input logic [CW-1:0]     level,
    input logic              empty,
    input logic              full,
    input logic              overrun
);

    // R1: the count never exceeds capacity and agrees with empty/full
    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= CW'(DEPTH)) && (empty == (level == '0)) && (full == (level == CW'(DEPTH))));

    // R2: an empty queue shows a zero head
    p_head_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (head_data == '0));

    // R3: no error can be reported while nothing is held
    p_err_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !err_any);

    // R5: a status read alone moves nothing
    p_stat_nopop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_stb && !rd_data_stb && !wr_en && !clr)
        |=> ($stable(level) && $stable(head_data) && $stable(err_any)));

    // R7: a write into a full queue is dropped and flags overrun
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_data_stb && !clr)
        |=> (level == $past(level)) && overrun);

    // R8: popping an empty queue has no effect
    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_data_stb && !wr_en && !clr) |=> empty);

    // R9: a synchronous clear empties everything
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !err_any && !overrun));

endmodule

bind rxq_err_fifo rxq_err_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .wr_en       (wr_en),
    .rd_data_stb (rd_data_stb),
    .rd_stat_stb (rd_stat_stb),
    .head_data   (head_data),
    .err_any     (err_any),
    .level       (level),
    .empty       (empty),
    .full        (full),
    .overrun     (overrun)
);

// File: tb/tb_rxq_err_fifo.sv
module tb_rxq_err_fifo;

    localparam int DW    = 8;
    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0]    wr_flags = '0;
    logic          rd_data_stb = 1'b0;
    logic          rd_stat_stb = 1'b0;
    logic [DW-1:0] head_data;
    logic [2:0]    head_flags;
    logic          err_any;
    logic [CW-1:0] level;
    logic          empty, full, overrun;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rxq_err_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
        .wr_flags(wr_flags), .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
        .head_data(head_data), .head_flags(head_flags), .err_any(err_any),
        .level(level), .empty(empty), .full(full), .overrun(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock cycle with the given strobes; returns at the following negedge
    task automatic cyc(input logic w, input logic [7:0] d, input logic [2:0] f,
                       input logic p, input logic s, input logic c);
        wr_en = w; wr_data = d; wr_flags = f; rd_data_stb = p; rd_stat_stb = s; clr = c;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_data_stb = 0; rd_stat_stb = 0; clr = 0;
    endtask

    typedef struct packed {
        logic       w;
        logic [7:0] d;
        logic [2:0] f;
        logic       p;
        logic       s;
        logic [6:0] lvl;
        logic       err;
        logic [7:0] hd;
        logic [2:0] hf;
    } vec_t;

    localparam int NV = 11;
    // flags: bit0 parity, bit1 framing, bit2 break
    localparam vec_t VEC [NV] = '{
        '{1, 8'hA1, 3'd0, 0, 0, 7'd1, 1'b0, 8'hA1, 3'd0},  // R1 R2 clean push
        '{1, 8'hB2, 3'd1, 0, 0, 7'd2, 1'b1, 8'hA1, 3'd0},  // R3 error behind clean head
        '{0, 8'h00, 3'd0, 0, 1, 7'd2, 1'b1, 8'hA1, 3'd0},  // R5 status read alone
        '{1, 8'hC3, 3'd0, 0, 0, 7'd3, 1'b1, 8'hA1, 3'd0},  // R1
        '{0, 8'h00, 3'd0, 1, 0, 7'd2, 1'b1, 8'hB2, 3'd1},  // R2 head flags follow head
        '{1, 8'hD4, 3'd4, 1, 0, 7'd2, 1'b1, 8'hC3, 3'd0},  // R6 err in and err out
        '{0, 8'h00, 3'd0, 1, 0, 7'd1, 1'b1, 8'hD4, 3'd4},  // R4 still one error left
        '{0, 8'h00, 3'd0, 1, 0, 7'd0, 1'b0, 8'h00, 3'd0},  // R4 last error gone, R2 zero
        '{1, 8'hE5, 3'd2, 1, 0, 7'd1, 1'b1, 8'hE5, 3'd2},  // R8 pop on empty ignored
        '{1, 8'h66, 3'd0, 1, 0, 7'd1, 1'b0, 8'h66, 3'd0},  // R6 clean in, error out
        '{0, 8'h00, 3'd0, 1, 0, 7'd0, 1'b0, 8'h00, 3'd0}   // R1 drained
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 level", int'(level), 0);
        chk("R10 empty", int'(empty), 1);
        chk("R10 full", int'(full), 0);
        chk("R10 err_any", int'(err_any), 0);
        chk("R10 overrun", int'(overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].w, VEC[i].d, VEC[i].f, VEC[i].p, VEC[i].s, 1'b0);
            chk($sformatf("R1 vec%0d level", i), int'(level), int'(VEC[i].lvl));
            chk($sformatf("R3 vec%0d err_any", i), int'(err_any), int'(VEC[i].err));
            chk($sformatf("R2 vec%0d head_data", i), int'(head_data), int'(VEC[i].hd));
            chk($sformatf("R2 vec%0d head_flags", i), int'(head_flags), int'(VEC[i].hf));
        end

        // fill with pointers offset (forces wrap); one error at slot 10
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1, 8'(i), (i == 10) ? 3'd1 : 3'd0, 0, 0, 0);
        end
        chk("R1 full level", int'(level), DEPTH);
        chk("R1 full flag", int'(full), 1);
        chk("R3 err while held", int'(err_any), 1);
        cyc(1, 8'hEE, 3'd7, 0, 0, 0);
        chk("R7 level kept", int'(level), DEPTH);
        chk("R7 overrun set", int'(overrun), 1);
        chk("R7 head kept", int'(head_data), 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R7 overrun sticky", int'(overrun), 1);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R7 overrun cleared by status read", int'(overrun), 0);
        chk("R5 status read keeps level", int'(level), DEPTH);

        for (int i = 0; i < DEPTH; i++) begin
            chk($sformatf("R1 order slot%0d", i), int'(head_data), i);
            cyc(0, 0, 0, 1, 0, 0);
            chk($sformatf("R4 err after pop%0d", i), int'(err_any), (i < 10) ? 1 : 0);
        end
        chk("R1 drained empty", int'(empty), 1);
        chk("R7 dropped char absent", int'(level), 0);

        // R9 synchronous clear
        cyc(1, 8'h11, 3'd4, 0, 0, 0);
        cyc(1, 8'h22, 3'd2, 0, 0, 0);
        cyc(1, 8'h33, 3'd0, 0, 0, 1);
        chk("R9 level", int'(level), 0);
        chk("R9 empty", int'(empty), 1);
        chk("R9 err_any", int'(err_any), 0);
        chk("R9 head_data", int'(head_data), 0);
        cyc(1, 8'h44, 3'd0, 0, 0, 0);
        chk("R9 restart head", int'(head_data), 8'h44);
        chk("R9 restart level", int'(level), 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule